// File: doc/BRIEF.md
# Four-Page Event Buffer Manager

This block sits between an event builder and a host, and holds finished events in a small set of pages. There are four pages by default, and each page holds exactly one event. The builder asks to start an event, streams its body words and then closes the event. The block places the body from page offset 1 upward. On close it writes a header word at offset 0, and only then does the page join the queue of finished events. Finished pages are shown to the host one at a time, always the oldest first, through a single window addressed by a page offset.

A host read of window offset 0 returns the header of the oldest event when one is waiting. When nothing is waiting, it returns a status word with bit 15 set that carries the page indices and the occupancy. A host write to offset 0 frees the shown page and brings the next finished one forward. The data of that write is not used, so there is no write-data port.

Two sampling policies decide whether the builder may start an event:
- **Sample-all mode:** the builder is held back while every page is occupied, so no event is ever lost.
- **Free-running mode:** the builder may always start. An event that found no free page when it began is still consumed, but it is thrown away.

The page size is `2**PAGE_AW` words, with `PAGE_AW` at most 13.

Top module: `evbuf_mgr`

## Requirements
- R1: After reset the occupancy is 0, both page indices are 0, `may_start_o` is 1, and a read of window offset 0 returns 0x8000.
- R2: An event is not visible while it is being written. A read of offset 0 before the close still returns a word with bit 15 set.
- R3: The header of a finished event has the following fields, and body word k (counting from 0) reads back at offset k+1:
  - bit 15 = 0;
  - bit 14 = the error flag given at close;
  - bits 13:0 = the number of words including the header.
- R4: Events are shown in the order in which they were closed. A write to offset 0 while an event is shown advances the read page index by one and decrements the occupancy.
- R5: A write to offset 0 when no event is shown is ignored. The occupancy and the read page index are unchanged.
- R6: In sample-all mode (`sample_all_i` = 1), `may_start_o` is 0 while the occupancy equals the page count, and a start request is not accepted (`capture_o` stays 0). The occupancy never exceeds the page count.
- R7: In free-running mode, a start made while all pages are occupied is consumed without capture. `capture_o` is 0, and the occupancy and write page index are unchanged after its close. A later start made when a page is free is captured.
- R8: The status word is laid out as follows:
  - bit 15 = 1;
  - bits 14:13 = write page index;
  - bits 12:11 = read page index;
  - bits 2:0 = occupancy;
  - all other bits 0.
- R9: Both page indices wrap from 3 to 0.
- R10: Body words beyond the page size are not stored. The header count saturates at the page size in words.
- R11: A close and a release in the same cycle leave the occupancy unchanged and advance both page indices.
- R12: A host write to a nonzero offset neither releases the shown page nor changes the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_all_i | input | 1 | 1: sample-all policy, 0: free-running policy |
| ev_start_i | input | 1 | Builder requests the start of an event |
| wr_valid_i | input | 1 | Body word valid |
| wr_data_i | input | 16 | Body word |
| ev_end_i | input | 1 | Close of the current event |
| ev_err_i | input | 1 | Error flag for the header, sampled with `ev_end_i` |
| may_start_o | output | 1 | Builder may start an event under the current policy |
| capture_o | output | 1 | Current event owns a page and is being stored |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe (data not used) |
| host_addr_i | input | PAGE_AW | Window offset |
| host_rdata_o | output | 16 | Read data, valid one cycle after `host_rd_i` |
| rd_page_o | output | 2 | Index of the page shown to the host |
| wr_page_o | output | 2 | Index of the next page to be filled |
| used_o | output | 3 | Number of finished, unreleased events |

## Verification
A corrupted occupancy count shows up at once on the ports:
- In sample-all mode, `may_start_o` would fall while space exists, or stay high when full.
- A read of offset 0 would return a header where a status word is expected, or the reverse.

A slipped read or write page index does not change any flag. It appears only on the next header read, as a wrong word count or a body word that belongs to another event. For that reason the bench checks both the header and the first body word of every event it drains, in the order the events were closed. A dropped-event fault in free-running mode is exposed by the occupancy and write index right after the close, and by the event sequence seen later.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CNT_FLD = 14;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t make_header(input logic err, input logic [CNT_FLD-1:0] cnt);
    return {1'b0, err, cnt};
  endfunction
endpackage

// File: rtl/evbuf_page_ctrl.sv
module evbuf_page_ctrl #(
  parameter int unsigned NUM_PAGES = 4,
  localparam int unsigned PIDX_W   = $clog2(NUM_PAGES),
  localparam int unsigned OCC_W    = $clog2(NUM_PAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              release_req_i,
  output logic [PIDX_W-1:0] rd_idx_o,
  output logic [PIDX_W-1:0] wr_idx_o,
  output logic [OCC_W-1:0]  used_o,
  output logic              avail_o,
  output logic              full_o
);
  localparam logic [OCC_W-1:0]  OCC_MAX  = OCC_W'(NUM_PAGES);
  localparam logic [PIDX_W-1:0] IDX_LAST = PIDX_W'(NUM_PAGES - 1);

  logic [PIDX_W-1:0] rd_q, wr_q;
  logic [OCC_W-1:0]  used_q;
  logic              rel;

  function automatic logic [PIDX_W-1:0] nxt(input logic [PIDX_W-1:0] i);
    return (i == IDX_LAST) ? '0 : i + 1'b1;
  endfunction

  assign rel = release_req_i && (used_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      used_q <= '0;
    end else begin
      if (commit_i) wr_q <= nxt(wr_q);
      if (rel)      rd_q <= nxt(rd_q);
      case ({commit_i, rel})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  assign rd_idx_o = rd_q;
  assign wr_idx_o = wr_q;
  assign used_o   = used_q;
  assign avail_o  = used_q != '0;
  assign full_o   = used_q == OCC_MAX;
endmodule

// File: rtl/evbuf_writer.sv
module evbuf_writer
  import evbuf_pkg::*;
#(
  parameter int unsigned PAGE_AW = 8,
  localparam int unsigned CNT_W  = PAGE_AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_all_i,
  input  logic               full_i,
  input  logic               ev_start_i,
  input  logic               wr_valid_i,
  input  word_t              wr_data_i,
  input  logic               ev_end_i,
  input  logic               ev_err_i,
  output logic               may_start_o,
  output logic               capture_o,
  output logic               commit_o,
  output logic               mem_we_o,
  output logic [PAGE_AW-1:0] mem_off_o,
  output word_t              mem_wdata_o
);
  localparam logic [CNT_W-1:0] PAGE_WORDS = CNT_W'(1) << PAGE_AW;

  logic             active_q, keep_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_ok, room, body_we;

  assign may_start_o = !(sample_all_i && full_i);
  assign start_ok    = ev_start_i && !active_q && may_start_o;
  assign room        = cnt_q < PAGE_WORDS;
  assign body_we     = active_q && keep_q && wr_valid_i && !ev_end_i && room;
  assign commit_o    = active_q && keep_q && ev_end_i;
  assign capture_o   = active_q && keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (start_ok) begin
      active_q <= 1'b1;
      keep_q   <= !full_i;   // page decision fixed at start
      cnt_q    <= CNT_W'(1); // header slot
    end else if (active_q && ev_end_i) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
    end else if (active_q && wr_valid_i && room) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mem_we_o    = body_we || commit_o;
  assign mem_off_o   = commit_o ? '0 : cnt_q[PAGE_AW-1:0];
  assign mem_wdata_o = commit_o ? make_header(ev_err_i, CNT_FLD'(cnt_q)) : wr_data_i;
endmodule

// File: rtl/evbuf_page_mem.sv
module evbuf_page_mem
  import evbuf_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PAGE_AW   = 8,
  localparam int unsigned PIDX_W   = $clog2(NUM_PAGES),
  localparam int unsigned PAGE_WORDS = 1 << PAGE_AW
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [PIDX_W-1:0]  wpage_i,
  input  logic [PAGE_AW-1:0] woff_i,
  input  word_t              wdata_i,
  input  logic [PIDX_W-1:0]  rpage_i,
  input  logic [PAGE_AW-1:0] roff_i,
  output word_t              rdata_o
);
  word_t bank_rd [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_bank
    word_t mem_q [PAGE_WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i && (wpage_i == PIDX_W'(g))) mem_q[woff_i] <= wdata_i;
    end
    assign bank_rd[g] = mem_q[roff_i];
  end

  assign rdata_o = bank_rd[rpage_i];
endmodule

// File: rtl/evbuf_mgr.sv
module evbuf_mgr
  import evbuf_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PAGE_AW   = 8,
  localparam int unsigned PIDX_W   = $clog2(NUM_PAGES),
  localparam int unsigned OCC_W    = $clog2(NUM_PAGES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_all_i,
  input  logic               ev_start_i,
  input  logic               wr_valid_i,
  input  logic [15:0]        wr_data_i,
  input  logic               ev_end_i,
  input  logic               ev_err_i,
  output logic               may_start_o,
  output logic               capture_o,
  input  logic               host_rd_i,
  input  logic               host_wr_i,
  input  logic [PAGE_AW-1:0] host_addr_i,
  output logic [15:0]        host_rdata_o,
  output logic [PIDX_W-1:0]  rd_page_o,
  output logic [PIDX_W-1:0]  wr_page_o,
  output logic [OCC_W-1:0]   used_o
);
  logic               commit, full, avail, mem_we, at_hdr;
  logic [PAGE_AW-1:0] mem_off;
  word_t              mem_wdata, mem_rd, status_w, rdata_q;
  logic [PIDX_W-1:0]  rd_idx, wr_idx;
  logic [OCC_W-1:0]   used;

  assign at_hdr = host_addr_i == '0;

  evbuf_page_ctrl #(.NUM_PAGES(NUM_PAGES)) u_ctrl (
    .clk_i, .rst_ni,
    .commit_i(commit), .release_req_i(host_wr_i && at_hdr),
    .rd_idx_o(rd_idx), .wr_idx_o(wr_idx), .used_o(used),
    .avail_o(avail), .full_o(full)
  );

  evbuf_writer #(.PAGE_AW(PAGE_AW)) u_wr (
    .clk_i, .rst_ni, .sample_all_i, .full_i(full),
    .ev_start_i, .wr_valid_i, .wr_data_i, .ev_end_i, .ev_err_i,
    .may_start_o, .capture_o, .commit_o(commit),
    .mem_we_o(mem_we), .mem_off_o(mem_off), .mem_wdata_o(mem_wdata)
  );

  evbuf_page_mem #(.NUM_PAGES(NUM_PAGES), .PAGE_AW(PAGE_AW)) u_mem (
    .clk_i, .we_i(mem_we), .wpage_i(wr_idx), .woff_i(mem_off), .wdata_i(mem_wdata),
    .rpage_i(rd_idx), .roff_i(host_addr_i), .rdata_o(mem_rd)
  );

  assign status_w = 16'h8000 | (16'(wr_idx) << 13) | (16'(rd_idx) << 11) | 16'(used);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (host_rd_i) rdata_q <= (at_hdr && !avail) ? status_w : mem_rd;
  end

  assign host_rdata_o = rdata_q;
  assign rd_page_o    = rd_idx;
  assign wr_page_o    = wr_idx;
  assign used_o       = used;
endmodule

// File: rtl/evbuf_mgr_chk.sv
module evbuf_mgr_chk #(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PAGE_AW   = 8,
  localparam int unsigned PIDX_W   = $clog2(NUM_PAGES),
  localparam int unsigned OCC_W    = $clog2(NUM_PAGES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_all_i,
  input logic               ev_start_i,
  input logic               ev_end_i,
  input logic               host_rd_i,
  input logic               host_wr_i,
  input logic [PAGE_AW-1:0] host_addr_i,
  input logic               may_start_o,
  input logic               capture_o,
  input logic [15:0]        host_rdata_o,
  input logic [PIDX_W-1:0]  rd_page_o,
  input logic [OCC_W-1:0]   used_o
);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(NUM_PAGES);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= OCC_MAX);

  a_r6_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_all_i && used_o == OCC_MAX) |-> !may_start_o);

  a_r5_empty_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == '0 && used_o == '0 && !ev_end_i)
      |=> (used_o == '0 && $stable(rd_page_o)));

  a_r4_rd_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == '0 && used_o != '0)
      |=> rd_page_o == PIDX_W'($past(rd_page_o) + 1'b1));

  a_r1_status_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == '0 && used_o == '0) |=> host_rdata_o[15]);

  a_r3_header_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == '0 && used_o != '0) |=> !host_rdata_o[15]);

  a_r7_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_start_i && !capture_o && used_o == OCC_MAX) |=> !capture_o);
endmodule

bind evbuf_mgr evbuf_mgr_chk #(.NUM_PAGES(NUM_PAGES), .PAGE_AW(PAGE_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_all_i(sample_all_i),
  .ev_start_i(ev_start_i), .ev_end_i(ev_end_i),
  .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
  .may_start_o(may_start_o), .capture_o(capture_o),
  .host_rdata_o(host_rdata_o), .rd_page_o(rd_page_o), .used_o(used_o)
);

// File: tb/evbuf_mgr_tb_top.sv
module evbuf_mgr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int AW  = 4;
  localparam int PW  = 1 << AW;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sample_all = 1'b1, ev_start = 1'b0, wr_valid = 1'b0, ev_end = 1'b0, ev_err = 1'b0;
  logic [15:0] wr_data = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic        may_start, capture;
  logic [15:0] rdata;
  logic [1:0]  rd_page, wr_page;
  logic [2:0]  used;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evbuf_mgr #(.NUM_PAGES(NP), .PAGE_AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_all_i(sample_all),
    .ev_start_i(ev_start), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .ev_end_i(ev_end), .ev_err_i(ev_err),
    .may_start_o(may_start), .capture_o(capture),
    .host_rd_i(host_rd), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_rdata_o(rdata), .rd_page_o(rd_page), .wr_page_o(wr_page), .used_o(used)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stat(input int wr, input int rd, input int u);
    return 16'h8000 | 16'(wr << 13) | 16'(rd << 11) | 16'(u);
  endfunction

  task automatic start_ev();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
  endtask
  task automatic push(input logic [15:0] d);
    wr_valid = 1'b1; wr_data = d; @(negedge clk); wr_valid = 1'b0;
  endtask
  task automatic close_ev(input logic e);
    ev_end = 1'b1; ev_err = e; @(negedge clk); ev_end = 1'b0; ev_err = 1'b0;
  endtask
  task automatic hread(input logic [AW-1:0] a, output logic [15:0] d);
    host_rd = 1'b1; host_addr = a; @(negedge clk); host_rd = 1'b0; d = rdata;
  endtask
  task automatic hwrite(input logic [AW-1:0] a);
    host_wr = 1'b1; host_addr = a; @(negedge clk); host_wr = 1'b0; host_addr = '0;
  endtask
  task automatic full_event(input int nbody, input logic [15:0] base, input logic e);
    start_ev();
    for (int i = 0; i < nbody; i++) push(base + 16'(i));
    close_ev(e);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 used", used, 0);
    chk("R1 rd_page", rd_page, 0);
    chk("R1 wr_page", wr_page, 0);
    chk("R1 may_start", may_start, 1);
    hread('0, d);
    chk("R1 status after reset", d, 16'h8000);
  endtask

  task automatic t_single();
    logic [15:0] d;
    start_ev();
    chk("R3 capture", capture, 1);
    push(16'hA000); push(16'hA001); push(16'hA002);
    hread('0, d);
    chk("R2 hidden while writing", d[15], 1);
    close_ev(1'b0);
    hread('0, d);
    chk("R3 header", d, 16'h0004);
    for (int i = 1; i <= 3; i++) begin
      hread(AW'(i), d);
      chk("R3 body word", d, 16'hA000 + 16'(i - 1));
    end
    hwrite('0);
    chk("R4 used after release", used, 0);
    hread('0, d);
    chk("R8 status fields", d, stat(1, 1, 0));
  endtask

  task automatic t_order();
    logic [15:0] d;
    sample_all = 1'b1;
    for (int k = 0; k < 4; k++) full_event(k + 1, 16'h1000 * 16'(k + 1), k == 1);
    chk("R6 used full", used, 4);
    chk("R9 wr_page wrapped", wr_page, 1);
    chk("R6 may_start low", may_start, 0);
    start_ev();
    chk("R6 start refused", capture, 0);
    push(16'hBAD0); close_ev(1'b0);
    chk("R6 used unchanged", used, 4);
    for (int k = 0; k < 4; k++) begin
      hread('0, d);
      chk("R4 header order", d, (k == 1 ? 16'h4000 : 16'h0) | 16'(k + 2));
      hread(AW'(1), d);
      chk("R4 first body", d, 16'h1000 * 16'(k + 1));
      hwrite('0);
      if (k == 2) chk("R9 rd_page wrapped", rd_page, 0);
    end
    chk("R4 drained", used, 0);
    hwrite('0);
    chk("R5 empty release used", used, 0);
    chk("R5 empty release rd_page", rd_page, 1);
    hread('0, d);
    chk("R8 status after drain", d, stat(1, 1, 0));
  endtask

  task automatic t_drop();
    logic [15:0] d;
    sample_all = 1'b0;
    for (int k = 0; k < 4; k++) full_event(1, 16'h2000 + 16'(k), 1'b0);
    chk("R7 may_start when full", may_start, 1);
    start_ev();
    chk("R7 no capture", capture, 0);
    push(16'hBAD1); push(16'hBAD2); close_ev(1'b0);
    chk("R7 used unchanged", used, 4);
    chk("R7 wr_page unchanged", wr_page, 1);
    hwrite('0);
    start_ev();
    chk("R7 capture with space", capture, 1);
    push(16'h3000); push(16'h3001); push(16'h3002); close_ev(1'b0);
    for (int k = 1; k < 4; k++) begin
      hread('0, d);
      chk("R7 kept header", d, 16'h0002);
      hread(AW'(1), d);
      chk("R7 kept body", d, 16'h2000 + 16'(k));
      hwrite('0);
    end
    hread('0, d);
    chk("R7 later event header", d, 16'h0004);
    hread(AW'(1), d);
    chk("R7 later event body", d, 16'h3000);
    hwrite('0);
    chk("R7 drained", used, 0);
  endtask

  task automatic t_trunc();
    logic [15:0] d;
    full_event(PW + 4, 16'h4000, 1'b0);
    hread('0, d);
    chk("R10 saturated count", d, 16'(PW));
    hread(AW'(PW - 1), d);
    chk("R10 last stored word", d, 16'h4000 + 16'(PW - 2));
    hread(AW'(1), d);
    chk("R10 first word intact", d, 16'h4000);
    hwrite('0);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    full_event(1, 16'h5000, 1'b0);
    start_ev(); push(16'h5100);
    ev_end = 1'b1; host_wr = 1'b1; host_addr = '0;
    @(negedge clk);
    ev_end = 1'b0; host_wr = 1'b0;
    chk("R11 used unchanged", used, 1);
    chk("R11 rd_page", rd_page, 0);
    chk("R11 wr_page", wr_page, 1);
    hread('0, d);
    chk("R11 new header", d, 16'h0002);
    hread(AW'(1), d);
    chk("R11 new body", d, 16'h5100);
    hwrite('0);
  endtask

  task automatic t_host_other();
    logic [15:0] d;
    full_event(2, 16'h6000, 1'b0);
    hwrite(AW'(1));
    chk("R12 used kept", used, 1);
    hread(AW'(1), d);
    chk("R12 body kept", d, 16'h6000);
    hwrite('0);
    chk("R12 final release", used, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_drop();
    t_trunc();
    t_same_cycle();
    t_host_other();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule